// File: doc/BRIEF.md
# Windowed External Interrupt Router

The router watches a set of external interrupt lines (24 by default) and turns each line that is pending and not masked into a delivery message. Each line has its own 64-bit routing entry. The entry decides whether the line reacts to a rising edge or to its level. It also supplies the vector, the delivery mode, the destination mode, the polarity flag and the trigger flag, and its top byte names the destination. Messages leave one at a time over a valid/ready stream. Lines are served lowest number first.

Software reaches the router over a 32-bit synchronous bus that decodes only two byte offsets. A write to the selector offset (0x00) picks an internal register. The data window (offset 0x10) then reads or writes the register that was picked. Each 64-bit routing entry takes two consecutive selector values, one for each 32-bit half. Reads return data in the cycle after the request and keep that value until the next read.

Stream rules: once `msg_valid` is high, the message fields hold their values until a cycle in which `msg_ready` is also high. A message transfers at every rising clock edge where both signals are high. When the consumer is ready, a new message can follow in the very next cycle. While the consumer stalls, pending lines go on collecting requests.

Top module: `irq_router`

## Requirements
- R1: After reset the selector, the ID and all pending state are zero, `msg_valid` is low, and each routing entry reads 0x00010000 (low half, mask bit 16 set) and 0x00000000 (high half).
- R2: A write to offset 0x00 loads bits 7:0 of the write data into the selector, and a read of 0x00 returns it in bits 7:0 with zeros above. A read of any offset other than 0x00 or 0x10 returns zero, and a write to such an offset is ignored. Read data appears one cycle after the request.
- R3: Selector 0x00 is the ID register. An 8-bit ID is held in window bits 31:24 and can be read and written. Bits 23:0 read as zero.
- R4: Selector 0x01 reads the version word 0x11 | ((pins-1) << 16), which is 0x00170011 for 24 pins. Writes to it are ignored.
- R5: Selector 0x10+2n is the low half (bits 31:0) of entry n, and selector 0x11+2n is its high half (bits 63:32). A write to one half leaves the other half unchanged. The last entry (n = 23) sits at selectors 0x3E and 0x3F.
- R6: Selectors 0x02 to 0x0F and all selectors from 0x10+2*pins (0x40) upward read as zero, and writes through the window to them change nothing.
- R7: An edge-mode line (entry bit 15 = 0) becomes pending on a 0-to-1 change of its input. It produces exactly one message for that change, however long the input stays high. Its pending bit clears when the message is loaded. Suppose a rise is sampled at clock edge k and the output is free. Then `msg_valid` goes high after edge k+1.
- R8: A level-mode line (bit 15 = 1) is pending while its input is high. It keeps producing messages for as long as the input stays high, and it produces none once the input is low.
- R9: A line whose mask bit 16 is set produces no message. An edge request that arrives while the line is masked is kept, and it is delivered once the mask is cleared.
- R10: The message carries vector = bits 7:0, delivery mode = bits 10:8, destination mode = bit 11, polarity = bit 13, trigger = bit 15 and destination = bits 63:56 of the entry.
- R11: When several unmasked lines are pending at the same time, the lowest-numbered line is issued first. The others follow in ascending order.
- R12: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and every message field stay stable. Exactly one message transfers for each cycle in which both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset (0x00 selector, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq_in | input | 24 | External interrupt lines, synchronous to clk |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts message |
| msg_dest | output | 8 | Destination field |
| msg_dest_mode | output | 1 | Destination mode flag |
| msg_dmode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Interrupt vector |
| msg_polarity | output | 1 | Polarity flag |
| msg_trigger | output | 1 | Trigger flag (1 = level) |

## Verification
Wrong internal state shows up at the ports within two or three cycles. A lost or duplicated edge-pending bit appears as a missing or extra message in the next free output slot. A routing entry that was decoded to the wrong index, or whose halves were merged badly, appears as a wrong read-back one cycle after the read. It also shows as wrong message fields the first time that line fires. A faulty arbitration or hold path shows as messages leaving out of ascending order, or as fields that change while the consumer stalls.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int ENT_VEC_LSB   = 0;
  localparam int ENT_DMODE_LSB = 8;
  localparam int ENT_DSTM_BIT  = 11;
  localparam int ENT_POL_BIT   = 13;
  localparam int ENT_TRIG_BIT  = 15;
  localparam int ENT_MASK_BIT  = 16;
  localparam int ENT_DEST_LSB  = 56;

  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] SEL_ID     = 8'h00;
  localparam logic [7:0] SEL_VER    = 8'h01;
  localparam logic [7:0] SEL_ENTRY0 = 8'h10;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] dmode;
    logic [7:0] vector;
    logic       polarity;
    logic       trigger;
  } route_msg_t;

  function automatic route_msg_t entry_to_msg(input logic [63:0] ent);
    route_msg_t m;
    m.dest      = ent[ENT_DEST_LSB +: 8];
    m.dest_mode = ent[ENT_DSTM_BIT];
    m.dmode     = ent[ENT_DMODE_LSB +: 3];
    m.vector    = ent[ENT_VEC_LSB +: 8];
    m.polarity  = ent[ENT_POL_BIT];
    m.trigger   = ent[ENT_TRIG_BIT];
    return m;
  endfunction

endpackage

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_en,
  input  logic                       bus_we,
  input  logic [7:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic [NUM_PINS-1:0][63:0]  tbl
);

  localparam logic [31:0] VERSION   = 32'h11 | (32'(NUM_PINS - 1) << 16);
  localparam logic [7:0]  SEL_LIMIT = 8'(16 + 2 * NUM_PINS);
  localparam logic [63:0] ENT_RESET = 64'(1) << ENT_MASK_BIT;

  logic [7:0]  sel_q;
  logic [7:0]  id_q;
  logic [31:0] win_val;
  logic [7:0]  ent_off;
  logic [IDX_W-1:0] ent_idx;
  logic        in_range;
  logic        win_wr;
  logic        win_rd;

  assign win_wr   = bus_en && bus_we && (bus_addr == OFF_WINDOW);
  assign win_rd   = bus_en && !bus_we && (bus_addr == OFF_WINDOW);
  assign in_range = (sel_q >= SEL_ENTRY0) && (sel_q < SEL_LIMIT);
  assign ent_off  = sel_q - SEL_ENTRY0;
  assign ent_idx  = ent_off[IDX_W:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (bus_en && bus_we && bus_addr == OFF_SELECT) sel_q <= bus_wdata[7:0];
      if (win_wr && sel_q == SEL_ID) id_q <= bus_wdata[31:24];
    end
  end

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_ent
    localparam logic [7:0] SEL_LO = 8'(16 + 2 * gi);
    localparam logic [7:0] SEL_HI = 8'(17 + 2 * gi);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl[gi] <= ENT_RESET;
      end else if (win_wr) begin
        if (sel_q == SEL_LO) tbl[gi][31:0]  <= bus_wdata;
        if (sel_q == SEL_HI) tbl[gi][63:32] <= bus_wdata;
      end
    end
  end

  always_comb begin
    win_val = '0;
    if (sel_q == SEL_ID)       win_val = {id_q, 24'h0};
    else if (sel_q == SEL_VER) win_val = VERSION;
    else if (in_range)         win_val = sel_q[0] ? tbl[ent_idx][63:32] : tbl[ent_idx][31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_we) begin
      if (bus_addr == OFF_SELECT)      bus_rdata <= {24'h0, sel_q};
      else if (bus_addr == OFF_WINDOW) bus_rdata <= win_val;
      else                             bus_rdata <= '0;
    end
  end

  AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd && sel_q == SEL_VER |=> bus_rdata == VERSION); // R4

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd && (sel_q >= SEL_LIMIT || (sel_q > SEL_VER && sel_q < SEL_ENTRY0))
    |=> bus_rdata == 32'h0); // R6

  AST_STRAY_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_we && bus_addr != OFF_SELECT && bus_addr != OFF_WINDOW
    |=> bus_rdata == 32'h0); // R2

endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] lvl_mode,
  input  logic [NUM_PINS-1:0] issue_clr,
  output logic [NUM_PINS-1:0] pend
);

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    logic rise;
    assign rise = irq_in[gi] && !prev_q[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pend[gi] <= 1'b0;
      else if (lvl_mode[gi])   pend[gi] <= irq_in[gi];
      else if (rise)           pend[gi] <= 1'b1;
      else if (issue_clr[gi])  pend[gi] <= 1'b0;
    end

    AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      issue_clr[gi] && !lvl_mode[gi] && !rise |=> !pend[gi]); // R7

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_mode[gi] |=> pend[gi] == $past(irq_in[gi])); // R8
  end

endmodule

// File: rtl/irq_msg_issue.sv
module irq_msg_issue
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        cand,
  input  logic [NUM_PINS-1:0][63:0]  tbl,
  input  logic                       msg_ready,
  output logic                       msg_valid,
  output route_msg_t                 msg,
  output logic                       issue_fire,
  output logic [IDX_W-1:0]           issue_idx,
  output logic [NUM_PINS-1:0]        issue_clr
);

  logic slot_free;

  always_comb begin
    issue_idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (cand[i]) issue_idx = IDX_W'(i);
    end
  end

  assign slot_free  = !msg_valid || msg_ready;
  assign issue_fire = slot_free && (|cand);

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_clr
    assign issue_clr[gi] = issue_fire && (issue_idx == IDX_W'(gi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg       <= '0;
    end else if (issue_fire) begin
      msg_valid <= 1'b1;
      msg       <= entry_to_msg(tbl[issue_idx]);
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg)); // R12

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_clr)); // R12

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_mode,
  output logic [2:0]          msg_dmode,
  output logic [7:0]          msg_vector,
  output logic                msg_polarity,
  output logic                msg_trigger
);

  logic [NUM_PINS-1:0][63:0] tbl;
  logic [NUM_PINS-1:0]       lvl_mode;
  logic [NUM_PINS-1:0]       masked;
  logic [NUM_PINS-1:0]       pend;
  logic [NUM_PINS-1:0]       cand;
  logic [NUM_PINS-1:0]       issue_clr;
  logic [NUM_PINS-1:0]       below;
  logic                      issue_fire;
  logic [IDX_W-1:0]          issue_idx;
  route_msg_t                msg;

  irq_route_table #(.NUM_PINS(NUM_PINS)) u_table (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tbl(tbl)
  );

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_cfg
    assign lvl_mode[gi] = tbl[gi][ENT_TRIG_BIT];
    assign masked[gi]   = tbl[gi][ENT_MASK_BIT];
  end

  irq_pend_track #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_mode(lvl_mode),
    .issue_clr(issue_clr), .pend(pend)
  );

  assign cand = pend & ~masked;

  irq_msg_issue #(.NUM_PINS(NUM_PINS)) u_issue (
    .clk(clk), .rst_n(rst_n), .cand(cand), .tbl(tbl), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg(msg), .issue_fire(issue_fire),
    .issue_idx(issue_idx), .issue_clr(issue_clr)
  );

  assign msg_dest      = msg.dest;
  assign msg_dest_mode = msg.dest_mode;
  assign msg_dmode     = msg.dmode;
  assign msg_vector    = msg.vector;
  assign msg_polarity  = msg.polarity;
  assign msg_trigger   = msg.trigger;

  assign below = (NUM_PINS'(1) << issue_idx) - NUM_PINS'(1);

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> (pend & ~masked & below) == '0); // R11

  AST_NO_MASKED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> pend[issue_idx] && !masked[issue_idx]); // R9

  AST_VECTOR_FROM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> msg_vector == $past(tbl[issue_idx][7:0])); // R10

endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [23:0] pins = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_dest, msg_vector;
  logic        msg_dest_mode, msg_polarity, msg_trigger;
  logic [2:0]  msg_dmode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] log_vec [32];
  logic       log_trig [32];
  int         log_cnt = 0;

  always #10 clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(pins), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode), .msg_dmode(msg_dmode),
    .msg_vector(msg_vector), .msg_polarity(msg_polarity), .msg_trigger(msg_trigger)
  );

  always @(negedge clk) begin
    #2;
    if (msg_valid && msg_ready) begin
      if (log_cnt < 32) begin
        log_vec[log_cnt]  = msg_vector;
        log_trig[log_cnt] = msg_trigger;
      end
      log_cnt++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic win_rd(input logic [7:0] sel, output logic [31:0] d);
    bus_wr(8'h00, {24'h0, sel});
    bus_rd(8'h10, d);
  endtask

  task automatic win_wr(input logic [7:0] sel, input logic [31:0] d);
    bus_wr(8'h00, {24'h0, sel});
    bus_wr(8'h10, d);
  endtask

  task automatic set_entry(input int n, input logic [31:0] lo, input logic [31:0] hi);
    win_wr(8'(16 + 2 * n), lo);
    win_wr(8'(17 + 2 * n), hi);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 msg_valid after reset", 64'(msg_valid), 64'h0);
    bus_rd(8'h00, d);
    chk("R1 selector after reset", 64'(d), 64'h0);
    bus_rd(8'h10, d);
    chk("R1 ID after reset", 64'(d), 64'h0);
    win_rd(8'h10, d);
    chk("R1 entry0 low after reset", 64'(d), 64'h0001_0000);
    win_rd(8'h3F, d);
    chk("R1 entry23 high after reset", 64'(d), 64'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_wr(8'h00, 32'hFFFF_FF2F);
    bus_rd(8'h00, d);
    chk("R2 selector readback", 64'(d), 64'h2F);
    bus_wr(8'h08, 32'h1234_5678);
    bus_rd(8'h08, d);
    chk("R2 stray offset reads zero", 64'(d), 64'h0);
    win_wr(8'h00, 32'hA5FF_FFFF);
    win_rd(8'h00, d);
    chk("R3 ID field", 64'(d), 64'hA500_0000);
    win_rd(8'h01, d);
    chk("R4 version", 64'(d), 64'h0017_0011);
    win_wr(8'h01, 32'hFFFF_FFFF);
    win_rd(8'h01, d);
    chk("R4 version read-only", 64'(d), 64'h0017_0011);
    win_wr(8'h1A, 32'h0001_2345);
    win_wr(8'h1B, 32'hDEAD_BEEF);
    win_rd(8'h1A, d);
    chk("R5 entry5 low", 64'(d), 64'h0001_2345);
    win_wr(8'h1A, 32'h0001_0077);
    win_rd(8'h1B, d);
    chk("R5 entry5 high kept", 64'(d), 64'hDEAD_BEEF);
    win_rd(8'h1A, d);
    chk("R5 entry5 low rewritten", 64'(d), 64'h0001_0077);
    win_wr(8'h3F, 32'hAB00_0000);
    win_wr(8'h40, 32'h1234_5678);
    win_rd(8'h40, d);
    chk("R6 select 0x40 reads zero", 64'(d), 64'h0);
    win_rd(8'h3F, d);
    chk("R6 entry23 high untouched by 0x40 write", 64'(d), 64'hAB00_0000);
    win_wr(8'h05, 32'hFFFF_FFFF);
    win_rd(8'h05, d);
    chk("R6 select 0x05 reads zero", 64'(d), 64'h0);
    win_rd(8'h00, d);
    chk("R6 ID untouched", 64'(d), 64'hA500_0000);
  endtask

  task automatic t_edge();
    msg_ready = 1'b0;
    set_entry(3, 32'h0000_2933, 32'h7C00_0000);
    @(negedge clk); pins[3] = 1'b1;
    @(negedge clk);
    chk("R7 not valid one edge after rise", 64'(msg_valid), 64'h0);
    @(negedge clk);
    chk("R7 valid two edges after rise", 64'(msg_valid), 64'h1);
    chk("R10 message fields",
        64'({msg_dest, msg_dest_mode, msg_dmode, msg_vector, msg_polarity, msg_trigger}),
        64'({8'h7C, 1'b1, 3'd1, 8'h33, 1'b1, 1'b0}));
    repeat (3) @(negedge clk);
    chk("R12 held while stalled",
        64'({msg_valid, msg_vector, msg_dest}), 64'({1'b1, 8'h33, 8'h7C}));
    pins[3] = 1'b0;
    log_cnt = 0;
    msg_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 one message per edge", 64'(log_cnt), 64'd1);
    chk("R12 valid drops after handshake", 64'(msg_valid), 64'h0);
  endtask

  task automatic t_level();
    int n;
    msg_ready = 1'b1;
    set_entry(4, 32'h0000_8044, 32'h0100_0000);
    @(negedge clk); log_cnt = 0; pins[4] = 1'b1;
    repeat (6) @(negedge clk);
    pins[4] = 1'b0;
    repeat (4) @(negedge clk);
    n = log_cnt;
    checks++;
    if (n < 3) begin
      errors++;
      $display("FAIL R8 repeated level messages: actual=%0d expected>=3", n);
    end
    chk("R8 level vector", 64'(log_vec[0]), 64'h44);
    chk("R10 level trigger flag", 64'(log_trig[0]), 64'h1);
    log_cnt = 0;
    repeat (6) @(negedge clk);
    chk("R8 none while low", 64'(log_cnt), 64'd0);
  endtask

  task automatic t_mask();
    msg_ready = 1'b1;
    set_entry(6, 32'h0001_0066, 32'h0200_0000);
    @(negedge clk); log_cnt = 0; pins[6] = 1'b1;
    repeat (3) @(negedge clk); pins[6] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 masked gives no message", 64'(log_cnt), 64'd0);
    win_wr(8'h1C, 32'h0000_0066);
    repeat (6) @(negedge clk);
    chk("R9 held request after unmask", 64'(log_cnt), 64'd1);
    chk("R9 unmasked vector", 64'(log_vec[0]), 64'h66);
  endtask

  task automatic t_order();
    msg_ready = 1'b0;
    set_entry(2, 32'h0000_0022, 32'h0);
    set_entry(9, 32'h0000_0099, 32'h0);
    set_entry(20, 32'h0000_00D4, 32'h0);
    @(negedge clk); pins[20] = 1'b1; pins[9] = 1'b1; pins[2] = 1'b1;
    repeat (4) @(negedge clk);
    pins[20] = 1'b0; pins[9] = 1'b0; pins[2] = 1'b0;
    chk("R11 lowest line presented first", 64'(msg_vector), 64'h22);
    log_cnt = 0;
    msg_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk("R11 three messages", 64'(log_cnt), 64'd3);
    chk("R11 order", 64'({log_vec[0], log_vec[1], log_vec[2]}), 64'h2299D4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edge();
    t_level();
    t_mask();
    t_order();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule